// File: doc/BRIEF.md
# Multi-Channel Vectored Interrupt Arbiter

The arbiter gathers interrupt requests from four serial channels. Each channel raises up to four kinds of request: receive, transmit, change of state and a catch-all "other" kind. Every source carries its own programmable 4-bit priority and its own enable. A source takes part only when it is pending, enabled and strictly above a global threshold. Among the sources that take part, the arbiter picks the single highest-priority one. From that source it builds a context word: a valid flag, the channel, the kind code, and, for receive and transmit kinds, the fill level of that channel's FIFO.

The host can read the context word at any time. It can also run an interrupt-acknowledge cycle by pulling the active-low acknowledge strobe low. At that falling edge the winner is frozen, and it stays frozen until the strobe rises again, even if requests change underneath. The vector byte is a host-programmed base value. It is either left as it is, or its low bits are replaced with the winner's channel, or with the channel together with the kind code.

Top module: `uia_arbiter_top`

## Requirements
- R1: One clock after its inputs settle, `irq_o` is high exactly when at least one source is pending, enabled and has a priority strictly greater than `thresh_i`. Outside an acknowledge hold it equals `ctx_o[10]`.
- R2: Source index s = channel*4 + kind. Its priority is `src_prio_i[4s+3:4s]`. The context reports the qualifying source with the numerically largest priority, one clock after the inputs. `ctx_o` = {valid[10], channel[9:8], kind[7:5], fill[4:0]}.
- R3: When priorities tie, the lower channel wins. Within one channel the lower kind code wins. Kind codes: receive=0, transmit=1, change-of-state=2, other=3.
- R4: The fill field is `rx_fill_i[5c+4:5c]` for a receive winner on channel c and `tx_fill_i[5c+4:5c]` for a transmit winner. It is zero for kinds 2 and 3.
- R5: When no source qualifies, `ctx_o` is all zeros.
- R6: With `vec_fmt_i` equal to 0 or 3, or with no valid winner, `vec_o` equals `vec_base_i`.
- R7: With `vec_fmt_i`=1 and a valid winner, `vec_o` = {base[7:2], channel}.
- R8: With `vec_fmt_i`=2 and a valid winner, `vec_o` = {base[7:5], channel, kind}.
- R9: The clock that first samples `iack_n_i` low loads the current winner into the context. While `iack_n_i` stays low, `ctx_o` and `vec_o` hold, whatever the requests, priorities or fill levels do. `irq_o` keeps tracking live.
- R10: One clock after `iack_n_i` returns high, the context again shows the live winner.
- R11: A source that is disabled, or whose priority is at or below the threshold, has no effect on `irq_o` or `ctx_o`.
- R12: During and right after reset, `irq_o`=0, `ctx_o`=0 and `vec_o` equals `vec_base_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 16 | Pending request per source, index channel*4+kind |
| src_en_i | input | 16 | Enable per source |
| src_prio_i | input | 64 | 4-bit priority per source |
| thresh_i | input | 4 | Sources must exceed this priority to qualify |
| vec_fmt_i | input | 2 | 0/3 plain, 1 channel, 2 channel and kind |
| vec_base_i | input | 8 | Programmed base vector |
| rx_fill_i | input | 20 | Receive FIFO fill, 5 bits per channel |
| tx_fill_i | input | 20 | Transmit FIFO fill, 5 bits per channel |
| iack_n_i | input | 1 | Interrupt-acknowledge strobe, active low |
| irq_o | output | 1 | Global interrupt request |
| vec_o | output | 8 | Vector byte |
| ctx_o | output | 11 | Context word of the winner |

## Verification
The bench sets up equal-priority requests across and within channels. An arbiter that searched in the wrong order, or let a later index win a tie, would report the wrong channel or kind. It places a source exactly at the threshold, and a strong source that is disabled; an off-by-one compare or a missing enable gate would raise `irq_o` for them. During an acknowledge it changes requests, priorities and fill levels, so a context that kept tracking would change mid-cycle. It then releases the strobe to catch a context that stayed stuck. Each vector format is checked with a base whose low bits are nonzero, so wrong bit positions show up as a changed byte.

// File: rtl/uia_pkg.sv
package uia_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    KIND_RX    = 3'd0,
    KIND_TX    = 3'd1,
    KIND_COS   = 3'd2,
    KIND_OTHER = 3'd3
  } src_kind_e;

  typedef enum logic [1:0] {
    VF_PLAIN     = 2'd0,
    VF_CHAN      = 2'd1,
    VF_CHAN_KIND = 2'd2,
    VF_PLAIN_ALT = 2'd3
  } vec_fmt_e;
endpackage

// File: rtl/uia_prio_select.sv
module uia_prio_select #(
  parameter int NUM_CH   = 4,
  parameter int NUM_KIND = 4,
  parameter int PRIO_W   = 4,
  localparam int NSRC    = NUM_CH * NUM_KIND,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NSRC-1:0]        req_i,
  input  logic [NSRC-1:0]        en_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]      thresh_i,
  output logic                   any_o,
  output logic [CH_W-1:0]        win_ch_o,
  output logic [uia_pkg::KIND_W-1:0] win_kind_o
);
  logic [NSRC-1:0] qual;

  // qualification per source
  for (genvar s = 0; s < NSRC; s++) begin : g_qual
    assign qual[s] = req_i[s] & en_i[s] & (prio_i[s*PRIO_W +: PRIO_W] > thresh_i);
  end

  // ascending scan with strict compare keeps the lowest index on ties
  always_comb begin
    logic [PRIO_W-1:0] best;
    any_o      = 1'b0;
    best       = '0;
    win_ch_o   = '0;
    win_kind_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int k = 0; k < NUM_KIND; k++) begin
        if (qual[c*NUM_KIND+k] &&
            (!any_o || (prio_i[(c*NUM_KIND+k)*PRIO_W +: PRIO_W] > best))) begin
          any_o      = 1'b1;
          best       = prio_i[(c*NUM_KIND+k)*PRIO_W +: PRIO_W];
          win_ch_o   = CH_W'(c);
          win_kind_o = uia_pkg::KIND_W'(k);
        end
      end
    end
  end
endmodule

// File: rtl/uia_ctx_build.sv
module uia_ctx_build #(
  parameter int NUM_CH = 4,
  parameter int FILL_W = 5,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CTX_W = 1 + CH_W + uia_pkg::KIND_W + FILL_W
) (
  input  logic                       any_i,
  input  logic [CH_W-1:0]            ch_i,
  input  logic [uia_pkg::KIND_W-1:0] kind_i,
  input  logic [NUM_CH*FILL_W-1:0]   rx_fill_i,
  input  logic [NUM_CH*FILL_W-1:0]   tx_fill_i,
  output logic [CTX_W-1:0]           ctx_o
);
  import uia_pkg::*;

  logic [FILL_W-1:0] rx_sel, tx_sel, fill;

  always_comb begin
    rx_sel = '0;
    tx_sel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_i == CH_W'(c)) begin
        rx_sel = rx_fill_i[c*FILL_W +: FILL_W];
        tx_sel = tx_fill_i[c*FILL_W +: FILL_W];
      end
    end
  end

  always_comb begin
    unique case (src_kind_e'(kind_i))
      KIND_RX: fill = rx_sel;
      KIND_TX: fill = tx_sel;
      default: fill = '0;
    endcase
  end

  assign ctx_o = any_i ? {1'b1, ch_i, kind_i, fill} : '0;
endmodule

// File: rtl/uia_vec_format.sv
module uia_vec_format #(
  parameter int CH_W   = 2,
  parameter int FILL_W = 5,
  parameter int VEC_W  = 8,
  localparam int KIND_W = uia_pkg::KIND_W,
  localparam int CTX_W  = 1 + CH_W + KIND_W + FILL_W,
  localparam int LOW_CK = CH_W + KIND_W
) (
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [1:0]       fmt_i,
  input  logic [VEC_W-1:0] base_i,
  output logic [VEC_W-1:0] vec_o
);
  import uia_pkg::*;

  logic              valid;
  logic [CH_W-1:0]   ch;
  logic [KIND_W-1:0] kind;
  logic [FILL_W-1:0] fill_unused;

  assign {valid, ch, kind, fill_unused} = ctx_i;

  always_comb begin
    vec_o = base_i;
    if (valid) begin
      unique case (vec_fmt_e'(fmt_i))
        VF_CHAN:      vec_o = {base_i[VEC_W-1:CH_W], ch};
        VF_CHAN_KIND: vec_o = {base_i[VEC_W-1:LOW_CK], ch, kind};
        default:      vec_o = base_i;
      endcase
    end
  end

  logic unused_ok;
  assign unused_ok = ^fill_unused;
endmodule

// File: rtl/uia_arbiter_top.sv
module uia_arbiter_top #(
  parameter int NUM_CH   = 4,
  parameter int NUM_KIND = 4,
  parameter int PRIO_W   = 4,
  parameter int FILL_W   = 5,
  parameter int VEC_W    = 8,
  localparam int NSRC    = NUM_CH * NUM_KIND,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CTX_W   = 1 + CH_W + uia_pkg::KIND_W + FILL_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_req_i,
  input  logic [NSRC-1:0]          src_en_i,
  input  logic [NSRC*PRIO_W-1:0]   src_prio_i,
  input  logic [PRIO_W-1:0]        thresh_i,
  input  logic [1:0]               vec_fmt_i,
  input  logic [VEC_W-1:0]         vec_base_i,
  input  logic [NUM_CH*FILL_W-1:0] rx_fill_i,
  input  logic [NUM_CH*FILL_W-1:0] tx_fill_i,
  input  logic                     iack_n_i,
  output logic                     irq_o,
  output logic [VEC_W-1:0]         vec_o,
  output logic [CTX_W-1:0]         ctx_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                       live_any;
  logic [CH_W-1:0]            live_ch;
  logic [uia_pkg::KIND_W-1:0] live_kind;
  logic [CTX_W-1:0]           live_ctx;

  uia_prio_select #(.NUM_CH(NUM_CH), .NUM_KIND(NUM_KIND), .PRIO_W(PRIO_W)) u_sel (
    .req_i(src_req_i), .en_i(src_en_i), .prio_i(src_prio_i), .thresh_i(thresh_i),
    .any_o(live_any), .win_ch_o(live_ch), .win_kind_o(live_kind)
  );

  uia_ctx_build #(.NUM_CH(NUM_CH), .FILL_W(FILL_W)) u_ctx (
    .any_i(live_any), .ch_i(live_ch), .kind_i(live_kind),
    .rx_fill_i(rx_fill_i), .tx_fill_i(tx_fill_i), .ctx_o(live_ctx)
  );

  // state
  logic             ack_prev_q, ack_prev_d;
  logic             irq_q, irq_d;
  logic [CTX_W-1:0] ctx_q, ctx_d;
  logic             ctx_en;

  // next state: context freezes once the strobe has been low for a full sample
  always_comb begin
    ack_prev_d = iack_n_i;
    irq_d      = live_any;
    ctx_en     = iack_n_i | ack_prev_q;
    ctx_d      = live_ctx;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ack_prev_q <= 1'b1;
      irq_q      <= 1'b0;
      ctx_q      <= '0;
    end else begin
      ack_prev_q <= ack_prev_d;
      irq_q      <= irq_d;
      if (ctx_en) ctx_q <= ctx_d;
    end
  end

  assign irq_o = irq_q;
  assign ctx_o = ctx_q;

  uia_vec_format #(.CH_W(CH_W), .FILL_W(FILL_W), .VEC_W(VEC_W)) u_vec (
    .ctx_i(ctx_q), .fmt_i(vec_fmt_i), .base_i(vec_base_i), .vec_o(vec_o)
  );
endmodule

// File: rtl/uia_arbiter_chk.sv
module uia_arbiter_chk #(
  parameter int CH_W   = 2,
  parameter int FILL_W = 5,
  parameter int VEC_W  = 8,
  localparam int KIND_W = uia_pkg::KIND_W,
  localparam int CTX_W  = 1 + CH_W + KIND_W + FILL_W
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             iack_n_i,
  input logic             ack_prev_q,
  input logic             irq_o,
  input logic [CTX_W-1:0] ctx_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [1:0]       vec_fmt_i,
  input logic [VEC_W-1:0] vec_base_i
);
  localparam int VALID_B = CTX_W - 1;
  localparam int KIND_LO = FILL_W;

  // R1
  irq_matches_ctx_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (iack_n_i && ack_prev_q) |=> (irq_o == ctx_o[VALID_B]));

  // R9
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!iack_n_i && !ack_prev_q) |=> $stable(ctx_o));

  // R5
  empty_ctx_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctx_o[VALID_B] |-> (ctx_o == '0));

  // R4
  fill_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctx_o[VALID_B] && (ctx_o[KIND_LO +: KIND_W] >= 3'd2)) |-> (ctx_o[FILL_W-1:0] == '0));

  // R6
  plain_vec_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (vec_fmt_i == 2'd0 || vec_fmt_i == 2'd3 || !ctx_o[VALID_B]) |-> (vec_o == vec_base_i));

  // R8
  chan_kind_vec_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctx_o[VALID_B] && vec_fmt_i == 2'd2) |->
      (vec_o[CH_W+KIND_W-1:0] == ctx_o[VALID_B-1:KIND_LO]));

  // R7
  chan_vec_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctx_o[VALID_B] && vec_fmt_i == 2'd1) |->
      (vec_o[CH_W-1:0] == ctx_o[VALID_B-1 -: CH_W]));
endmodule

bind uia_arbiter_top uia_arbiter_chk #(.CH_W(CH_W), .FILL_W(FILL_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .iack_n_i(iack_n_i), .ack_prev_q(ack_prev_q),
  .irq_o(irq_o), .ctx_o(ctx_o), .vec_o(vec_o), .vec_fmt_i(vec_fmt_i), .vec_base_i(vec_base_i)
);

// File: tb/tb_uia_arbiter_top.sv
module tb_uia_arbiter_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] req, en;
  logic [63:0] prio;
  logic [3:0]  thr;
  logic [1:0]  fmt;
  logic [7:0]  base;
  logic [19:0] rxf, txf;
  logic        iack_n;
  logic        irq;
  logic [7:0]  vec;
  logic [10:0] ctx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  uia_arbiter_top dut (
    .clk(clk), .rst_n(rst_n), .src_req_i(req), .src_en_i(en), .src_prio_i(prio),
    .thresh_i(thr), .vec_fmt_i(fmt), .vec_base_i(base), .rx_fill_i(rxf), .tx_fill_i(txf),
    .iack_n_i(iack_n), .irq_o(irq), .vec_o(vec), .ctx_o(ctx)
  );

  function automatic logic [10:0] mk_ctx(input int ch, input int kind, input int fill);
    return {1'b1, 2'(ch), 3'(kind), 5'(fill)};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic src(input int ch, input int kind, input int p, input bit on);
    int s = ch*4 + kind;
    prio[s*4 +: 4] = 4'(p);
    req[s] = on;
    en[s]  = 1'b1;
  endtask

  task automatic clear_all();
    req = '0; en = '0; prio = '0; thr = '0; fmt = 2'd0;
    rxf = '0; txf = '0; iack_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R12 irq", 16'(irq), 16'h0);
    chk("R12 ctx", 16'(ctx), 16'h0);
    chk("R12 vec", 16'(vec), 16'hB4);
  endtask

  task automatic t_single();
    clear_all();
    rxf[2*5 +: 5] = 5'd9;
    src(2, 0, 5, 1'b1);
    step();
    chk("R1 irq single", 16'(irq), 16'h1);
    chk("R2/R4 rx winner", 16'(ctx), 16'(mk_ctx(2, 0, 9)));
  endtask

  task automatic t_priority();
    clear_all();
    txf[0 +: 5] = 5'd4;
    src(0, 1, 3, 1'b1);
    src(3, 2, 7, 1'b1);
    step();
    chk("R2/R4 cos beats tx", 16'(ctx), 16'(mk_ctx(3, 2, 0)));
    src(3, 2, 7, 1'b0);
    step();
    chk("R4 tx fill", 16'(ctx), 16'(mk_ctx(0, 1, 4)));
  endtask

  task automatic t_ties();
    clear_all();
    txf[1*5 +: 5] = 5'd16;
    src(1, 3, 6, 1'b1);
    src(1, 1, 6, 1'b1);
    src(3, 0, 6, 1'b1);
    step();
    chk("R3 lower kind in channel", 16'(ctx), 16'(mk_ctx(1, 1, 16)));
    req[1*4+1] = 1'b0;
    step();
    chk("R3 lower channel", 16'(ctx), 16'(mk_ctx(1, 3, 0)));
  endtask

  task automatic t_threshold();
    clear_all();
    thr = 4'd4;
    src(0, 2, 4, 1'b1);
    src(2, 3, 15, 1'b1);
    en[2*4+3] = 1'b0;
    step();
    chk("R11 irq at threshold / disabled", 16'(irq), 16'h0);
    chk("R5 empty ctx", 16'(ctx), 16'h0);
    thr = 4'd3;
    step();
    chk("R1 irq above threshold", 16'(irq), 16'h1);
    chk("R11 disabled ignored", 16'(ctx), 16'(mk_ctx(0, 2, 0)));
  endtask

  task automatic t_formats();
    clear_all();
    src(2, 2, 9, 1'b1);
    step();
    fmt = 2'd0; #1 chk("R6 plain", 16'(vec), 16'hB4);
    fmt = 2'd1; #1 chk("R7 channel", 16'(vec), 16'hB6);
    fmt = 2'd2; #1 chk("R8 channel+kind", 16'(vec), 16'hB2);
    fmt = 2'd3; #1 chk("R6 plain alt", 16'(vec), 16'hB4);
    req = '0; fmt = 2'd2;
    step();
    chk("R6 no winner", 16'(vec), 16'hB4);
  endtask

  task automatic t_iack();
    clear_all();
    rxf[1*5 +: 5] = 5'd3;
    src(1, 0, 8, 1'b1);
    fmt = 2'd2;
    step();
    iack_n = 1'b0;
    step();
    chk("R9 latched", 16'(ctx), 16'(mk_ctx(1, 0, 3)));
    src(3, 1, 12, 1'b1);
    txf[3*5 +: 5] = 5'd7;
    rxf[1*5 +: 5] = 5'd11;
    step();
    step();
    chk("R9 ctx held", 16'(ctx), 16'(mk_ctx(1, 0, 3)));
    chk("R9 vec held", 16'(vec), 16'hA8);
    chk("R9 irq live", 16'(irq), 16'h1);
    req = '0;
    step();
    chk("R9 irq live drop", 16'(irq), 16'h0);
    chk("R9 ctx held after drop", 16'(ctx), 16'(mk_ctx(1, 0, 3)));
    src(3, 1, 12, 1'b1);
    iack_n = 1'b1;
    step();
    chk("R10 tracks again", 16'(ctx), 16'(mk_ctx(3, 1, 7)));
    chk("R10 vec new", 16'(vec), 16'hB9);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    clear_all();
    base  = 8'hB4;
    rst_n = 1'b0;
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_single();
    t_priority();
    t_ties();
    t_threshold();
    t_formats();
    t_iack();
    finish_run();
  end
endmodule